// File: doc/BRIEF.md
# Routable Interrupt Aggregator

This block collects two groups of sixteen level-sensitive interrupt sources and steers them onto five CPU interrupt lines. Every source has a status bit that shows its live input level and an enable bit that masks it. A source is active when its level is high and its enable bit is set. Most sources also have a 3-bit routing field that names the line they drive. Each line is the registered OR of the active sources routed to it.

Software reaches the block through a 16-bit register bus. The bus has a window select and a byte offset that must be halfword aligned. Window A holds the group A status and enable registers and all four routing registers. Window B holds the group B status and enable registers. Writes take effect at the clock edge. Read data is combinational from the current state. The fields are packed into the routing registers in an irregular order, and a source with no field always drives line 0.

Top module: `irq_route_agg`

## Requirements
- R1: A read of offset 0x00 returns the current level of `src_a` in window A, and of `src_b` in window B.
- R2: A source can raise a line only when its status bit and its enable bit are both 1. While both enable registers hold 0, every line stays low.
- R3: Each `irq_line[l]` is the OR of the active sources whose route is l. A line changes one clock edge after the change at its inputs, and not before that edge.
- R4: A routing field value of 0 to 4 selects line 0 to 4. A write that carries a value of 5, 6 or 7 for a field leaves that field unchanged, while other fields in the same write are still updated.
- R5: In window A, routing register 0x04 holds the group A fields for pins 0, 1, 2, 3 and 8 at bits 0, 3, 6, 9 and 12. Routing register 0x06 holds group A pin 9 at bit 0, pin 11 at bit 6 and pin 12 at bit 9.
- R6: In window A, routing register 0x1C holds the group B fields for pins 0, 1, 3, 4 and 5 at bits 0, 3, 6, 9 and 12. Routing register 0x1E holds group B pins 6, 7, 8, 9 and 10 at the same bit positions.
- R7: After reset both enable registers read 0 and all lines are low. Group A pin 2 routes to line 1, group B pin 0 routes to line 2, and every other field holds 0. Routing register 0x04 therefore reads 0x0040, 0x1C reads 0x0002, and 0x06 and 0x1E read 0.
- R8: A pin with no routing field always drives line 0. Routing register bits that carry no field read 0 and ignore writes.
- R9: The status registers ignore writes. Reads of unmapped offsets (any offset other than those listed, including odd ones) return 0, and writes to them change no state.
- R10: The group A enable register is read and written at window A offset 0x0C. The group B enable register is read and written at window B offset 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 16 | Group A source levels |
| src_b | input | 16 | Group B source levels |
| bus_win | input | 1 | Register window select: 0 = A, 1 = B |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current window and offset |
| irq_line | output | 5 | CPU interrupt lines 0 to 4 |

## Verification
The sources are driven with full-ones and alternating patterns while the enables are cleared. This tells masking apart from routing. Single-source patterns on pins with fields in each of the four routing registers confirm that every field sits at the right bit and selects the right line. Unroutable pins confirm the fixed line 0. Several sources are then driven onto distinct lines and dropped one at a time. This separates the per-line OR from a shared OR and shows the one-edge latency on both the rising and the falling side. Writes with out-of-range field values, writes into unused bits and writes to unmapped offsets are each followed by read-back, to show that nothing was disturbed.

// File: rtl/irq_route_agg_pkg.sv
package irq_route_agg_pkg;
  localparam int SRC_N   = 16;
  localparam int GROUP_N = 2;
  localparam int LINE_N  = 5;
  localparam int FLD_W   = 3;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int RT_N    = 4;

  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RT0  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RT1  = 5'h06;
  localparam logic [ADDR_W-1:0] OFS_ENA  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_RT2  = 5'h1C;
  localparam logic [ADDR_W-1:0] OFS_RT3  = 5'h1E;
  localparam logic [ADDR_W-1:0] OFS_ENB  = 5'h06;

  typedef struct packed {
    logic       ok;
    logic [1:0] rsel;
    logic [3:0] lsb;
  } fld_loc_t;

  function automatic fld_loc_t mk_loc(input int unsigned r, input int unsigned b);
    fld_loc_t v;
    v.ok   = 1'b1;
    v.rsel = 2'(r);
    v.lsb  = 4'(b);
    return v;
  endfunction

  // Where a pin's routing field lives: register index and bit position.
  function automatic fld_loc_t fld_loc(input int unsigned grp, input int unsigned pin);
    fld_loc_t v;
    v = '0;
    case (grp * 16 + pin)
      0:  v = mk_loc(0, 0);
      1:  v = mk_loc(0, 3);
      2:  v = mk_loc(0, 6);
      3:  v = mk_loc(0, 9);
      8:  v = mk_loc(0, 12);
      9:  v = mk_loc(1, 0);
      11: v = mk_loc(1, 6);
      12: v = mk_loc(1, 9);
      16: v = mk_loc(2, 0);
      17: v = mk_loc(2, 3);
      19: v = mk_loc(2, 6);
      20: v = mk_loc(2, 9);
      21: v = mk_loc(2, 12);
      22: v = mk_loc(3, 0);
      23: v = mk_loc(3, 3);
      24: v = mk_loc(3, 6);
      25: v = mk_loc(3, 9);
      26: v = mk_loc(3, 12);
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [FLD_W-1:0] rst_line(input int unsigned grp, input int unsigned pin);
    if (grp == 0 && pin == 2) return 3'd1;
    if (grp == 1 && pin == 0) return 3'd2;
    return 3'd0;
  endfunction
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_agg_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  bus_win,
  input  logic [ADDR_W-1:0]                     bus_addr,
  input  logic                                  bus_wr,
  input  logic [DATA_W-1:0]                     bus_wdata,
  input  logic [SRC_N-1:0]                      src_a,
  input  logic [SRC_N-1:0]                      src_b,
  output logic [DATA_W-1:0]                     bus_rdata,
  output logic [SRC_N-1:0]                      en_a,
  output logic [SRC_N-1:0]                      en_b,
  output logic [GROUP_N-1:0][SRC_N-1:0][FLD_W-1:0] route
);
  localparam logic [FLD_W-1:0] LINE_MAX = FLD_W'(LINE_N - 1);

  logic            wr_a, wr_b;
  logic            en_a_ce, en_b_ce;
  logic [RT_N-1:0] rt_we;
  logic [SRC_N-1:0] en_a_q, en_b_q;
  logic [RT_N-1:0][DATA_W-1:0] rt_img;

  always_comb begin
    wr_a     = bus_wr && !bus_win;
    wr_b     = bus_wr &&  bus_win;
    en_a_ce  = wr_a && (bus_addr == OFS_ENA);
    en_b_ce  = wr_b && (bus_addr == OFS_ENB);
    rt_we[0] = wr_a && (bus_addr == OFS_RT0);
    rt_we[1] = wr_a && (bus_addr == OFS_RT1);
    rt_we[2] = wr_a && (bus_addr == OFS_RT2);
    rt_we[3] = wr_a && (bus_addr == OFS_RT3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a_q <= '0;
      en_b_q <= '0;
    end else begin
      if (en_a_ce) en_a_q <= bus_wdata;
      if (en_b_ce) en_b_q <= bus_wdata;
    end
  end

  assign en_a = en_a_q;
  assign en_b = en_b_q;

  // Enable holds unless its own offset is written (R10)
  p_enable_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a_ce && !en_b_ce) |=> ($stable(en_a_q) && $stable(en_b_q)));

  for (genvar g = 0; g < GROUP_N; g++) begin : g_grp
    for (genvar p = 0; p < SRC_N; p++) begin : g_pin
      localparam fld_loc_t LOC = fld_loc(g, p);
      if (LOC.ok) begin : g_fld
        localparam int RS  = int'(LOC.rsel);
        localparam int LSB = int'(LOC.lsb);
        logic [FLD_W-1:0] f_q, f_d, wf;
        logic             f_ce;

        always_comb begin
          wf   = bus_wdata[LSB +: FLD_W];
          f_ce = rt_we[RS] && (wf <= LINE_MAX);
          f_d  = wf;
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)    f_q <= rst_line(g, p);
          else if (f_ce) f_q <= f_d;
        end

        assign route[g][p] = f_q;

        p_field_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
          f_q <= LINE_MAX);
        p_bad_value_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
          (rt_we[RS] && (bus_wdata[LSB +: FLD_W] > LINE_MAX)) |=> $stable(f_q));
      end else begin : g_fixed
        // No field: fixed to line 0 (R8)
        assign route[g][p] = '0;
      end
    end
  end

  always_comb begin
    fld_loc_t loc;
    rt_img = '0;
    for (int g = 0; g < GROUP_N; g++) begin
      for (int p = 0; p < SRC_N; p++) begin
        loc = fld_loc(g, p);
        if (loc.ok) rt_img[loc.rsel][loc.lsb +: FLD_W] = route[g][p];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_win) begin
      case (bus_addr)
        OFS_STAT: bus_rdata = src_a;
        OFS_RT0:  bus_rdata = rt_img[0];
        OFS_RT1:  bus_rdata = rt_img[1];
        OFS_ENA:  bus_rdata = en_a_q;
        OFS_RT2:  bus_rdata = rt_img[2];
        OFS_RT3:  bus_rdata = rt_img[3];
        default:  bus_rdata = '0;
      endcase
    end else begin
      case (bus_addr)
        OFS_STAT: bus_rdata = src_b;
        OFS_ENB:  bus_rdata = en_b_q;
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_route_combine.sv
module irq_route_combine
  import irq_route_agg_pkg::*;
(
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [SRC_N-1:0]                         src_a,
  input  logic [SRC_N-1:0]                         src_b,
  input  logic [SRC_N-1:0]                         en_a,
  input  logic [SRC_N-1:0]                         en_b,
  input  logic [GROUP_N-1:0][SRC_N-1:0][FLD_W-1:0] route,
  output logic [LINE_N-1:0]                        irq_q
);
  logic [GROUP_N-1:0][SRC_N-1:0] act;
  logic [LINE_N-1:0]             line_d;

  always_comb begin
    act[0] = src_a & en_a;
    act[1] = src_b & en_b;
    line_d = '0;
    for (int l = 0; l < LINE_N; l++) begin
      for (int g = 0; g < GROUP_N; g++) begin
        for (int p = 0; p < SRC_N; p++) begin
          if (act[g][p] && (route[g][p] == FLD_W'(l))) line_d[l] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= line_d;
  end

  // All sources masked -> all lines low on the next edge (R2)
  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_a == '0) && (en_b == '0)) |=> (irq_q == '0));
endmodule

// File: rtl/irq_route_agg.sv
module irq_route_agg
  import irq_route_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_a,
  input  logic [SRC_N-1:0]  src_b,
  input  logic              bus_win,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LINE_N-1:0] irq_line
);
  logic [SRC_N-1:0] en_a, en_b;
  logic [GROUP_N-1:0][SRC_N-1:0][FLD_W-1:0] route;

  irq_route_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_win   (bus_win),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .src_a     (src_a),
    .src_b     (src_b),
    .bus_rdata (bus_rdata),
    .en_a      (en_a),
    .en_b      (en_b),
    .route     (route)
  );

  irq_route_combine u_comb (
    .clk   (clk),
    .rst_n (rst_n),
    .src_a (src_a),
    .src_b (src_b),
    .en_a  (en_a),
    .en_b  (en_b),
    .route (route),
    .irq_q (irq_line)
  );

  // Status bits ignore writes (R1, R9)
  p_status_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_win && bus_addr == OFS_STAT) |-> (bus_rdata == src_a));
endmodule

// File: tb/irq_route_agg_bench.sv
module irq_route_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_a = '0, src_b = '0;
  logic        bus_win = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [4:0]  irq_line;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_route_agg u_irq_route_agg (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .bus_win(bus_win), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic win, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_win = win; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic win, input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_win = win; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R7 lines after reset", {11'd0, irq_line}, 16'h0000);
    rd(0, 5'h0C, d); chk("R7 enable A reset", d, 16'h0000);
    rd(1, 5'h06, d); chk("R7 enable B reset", d, 16'h0000);
    rd(0, 5'h04, d); chk("R7 route reg 0x04 reset", d, 16'h0040);
    rd(0, 5'h06, d); chk("R7 route reg 0x06 reset", d, 16'h0000);
    rd(0, 5'h1C, d); chk("R7 route reg 0x1C reset", d, 16'h0002);
    rd(0, 5'h1E, d); chk("R7 route reg 0x1E reset", d, 16'h0000);
  endtask

  task automatic t_status();
    logic [15:0] d;
    src_a = 16'hA5A5; src_b = 16'h1234;
    rd(0, 5'h00, d); chk("R1 status A", d, 16'hA5A5);
    rd(1, 5'h00, d); chk("R1 status B", d, 16'h1234);
    wr(0, 5'h00, 16'hFFFF);
    rd(0, 5'h00, d); chk("R9 status A ignores write", d, 16'hA5A5);
    settle();
    chk("R2 masked sources keep lines low", {11'd0, irq_line}, 16'h0000);
    src_a = '0; src_b = '0;
  endtask

  task automatic t_mask();
    src_a = 16'hFFFF;
    wr(0, 5'h0C, 16'h0004);
    settle();
    chk("R2 only enabled pin 2 -> line 1", {11'd0, irq_line}, 16'h0002);
    wr(0, 5'h0C, 16'h0000);
    settle();
    chk("R2 mask cleared -> lines low", {11'd0, irq_line}, 16'h0000);
    src_a = '0;
  endtask

  task automatic t_route_a();
    logic [15:0] d;
    wr(0, 5'h04, 16'h0044);
    rd(0, 5'h04, d); chk("R5 route reg 0x04 readback", d, 16'h0044);
    wr(0, 5'h04, 16'h0047);
    rd(0, 5'h04, d); chk("R4 value 7 ignored, other field kept", d, 16'h0044);
    wr(0, 5'h0C, 16'h0001);
    src_a = 16'h0001;
    settle();
    chk("R4 pin 0 routed to line 4", {11'd0, irq_line}, 16'h0010);
    wr(0, 5'h06, 16'h088B);
    rd(0, 5'h06, d); chk("R8 unused bit reads 0 in 0x06", d, 16'h0883);
    wr(0, 5'h0C, 16'h0800);
    src_a = 16'h0800;
    settle();
    chk("R5 pin 11 routed to line 2", {11'd0, irq_line}, 16'h0004);
    wr(0, 5'h0C, 16'h0400);
    src_a = 16'h0400;
    settle();
    chk("R8 unroutable pin 10 on line 0", {11'd0, irq_line}, 16'h0001);
    src_a = '0;
  endtask

  task automatic t_route_b();
    logic [15:0] d;
    wr(1, 5'h06, 16'h0001);
    rd(1, 5'h06, d); chk("R10 enable B readback", d, 16'h0001);
    src_b = 16'h0001;
    settle();
    chk("R7 group B pin 0 default line 2", {11'd0, irq_line}, 16'h0004);
    wr(0, 5'h1E, 16'h3000);
    rd(0, 5'h1E, d); chk("R6 route reg 0x1E readback", d, 16'h3000);
    wr(0, 5'h1C, 16'h0022);
    rd(0, 5'h1C, d); chk("R6 route reg 0x1C readback", d, 16'h0022);
    wr(1, 5'h06, 16'h0404);
    src_b = 16'h0404;
    settle();
    chk("R8 group B pin 2 fixed line 0 and R6 pin 10 line 3",
        {11'd0, irq_line}, 16'h0009);
    src_b = '0;
  endtask

  task automatic t_combine();
    wr(1, 5'h06, 16'h0403);
    settle();
    chk("R3 no source -> low", {11'd0, irq_line}, 16'h0000);
    @(negedge clk);
    src_b = 16'h0403;
    #1 chk("R3 no change before edge", {11'd0, irq_line}, 16'h0000);
    @(negedge clk);
    chk("R3 three lines one edge later", {11'd0, irq_line}, 16'h001C);
    src_b = 16'h0401;
    #1 chk("R3 held before edge", {11'd0, irq_line}, 16'h001C);
    @(negedge clk);
    chk("R3 line 4 drops one edge later", {11'd0, irq_line}, 16'h000C);
    src_a = 16'h0400;
    settle();
    chk("R3 group A and B sharing lines", {11'd0, irq_line}, 16'h000D);
    src_a = '0; src_b = '0;
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    wr(0, 5'h02, 16'hFFFF);
    rd(0, 5'h02, d); chk("R9 unmapped A 0x02 reads 0", d, 16'h0000);
    wr(1, 5'h04, 16'hFFFF);
    rd(1, 5'h04, d); chk("R9 unmapped B 0x04 reads 0", d, 16'h0000);
    wr(1, 5'h0C, 16'hFFFF);
    rd(1, 5'h0C, d); chk("R9 window B 0x0C reads 0", d, 16'h0000);
    wr(0, 5'h05, 16'hFFFF);
    rd(0, 5'h0C, d); chk("R9 enable A untouched", d, 16'h0400);
    rd(1, 5'h06, d); chk("R9 enable B untouched", d, 16'h0403);
    rd(0, 5'h04, d); chk("R9 route 0x04 untouched", d, 16'h0044);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_mask();
    t_route_a();
    t_route_b();
    t_combine();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule